// File: doc/BRIEF.md
# Bottleneck-Driven Core Steering Unit

This unit sits beside a running core in a chip that mixes several core types. Each cycle the core reports one-bit stall and event strobes, plus how many instructions it retired. The unit accumulates them over a window of a fixed number of retired instructions. At the end of each window it turns every event count into a rate per cycle and compares that rate with a programmable threshold. From the resulting bottleneck vector it picks the core type the thread should run on next. The four core types are the balanced average core, a wide-issue core, a large-window core and a fast-clock narrow core.

The decision goes through a small state machine with four states. ST_COUNT accumulates events, cycles and retired instructions. It moves to ST_EVAL on the cycle in which the retired total reaches the window length. ST_EVAL registers the bottleneck vector from the frozen counters and always moves on to ST_DECIDE. ST_DECIDE registers the chosen core and clears all counters. It moves to ST_HOLD when the chosen core differs from the current one, and back to ST_COUNT when it matches. ST_HOLD waits out the migration cost with all inputs ignored, then returns to ST_COUNT. When a change of core is chosen, a migrate request is raised for one cycle. The actual transfer of the thread is left to other logic.

Top module: `core_steer_unit`

## Requirements
- R1: While reset is asserted, and on leaving it, the bottleneck vector is 0, the target core code is 0 (average core) and the migrate request is low.
- R2: A window closes in the cycle in which the running sum of `retire_cnt` (which may exceed 1 per cycle) reaches WINDOW_INSNS. Events and cycles of that cycle are included. The new bottleneck vector appears two clock edges after that cycle's edge. The target code and the migrate request appear three edges after it.
- R3: An event's bottleneck bit is set only when count × 256 > threshold × window cycles. The thresholds are unsigned with 8 fractional bits. Equality does not set the bit. Vector bit positions: 0 issue width, 1 dispatch window, 2 frequency, 3 instruction cache, 4 data cache.
- R4: The frequency bit (bit 2) is set when the misprediction rate or the L2-stall rate exceeds its own threshold.
- R5: Target codes are 0 average, 1 wide, 2 large-window and 3 fast narrow. The rules are checked in this priority order: wide if width is set and frequency is clear; otherwise large-window if window is set and frequency is clear; otherwise fast narrow if frequency is set and both width and window are clear; otherwise average.
- R6: A window with no bottleneck bit set selects the average core.
- R7: The migrate request is high for exactly one cycle, and only when the new target code differs from the previous one. Otherwise the target code is left unchanged.
- R8: After a migrate request, the unit ignores events and retire counts for MIGRATE_CYCLES cycles (default 100). The next window starts counting from zero after that.
- R9: The event counters and the cycle counter saturate at their all-ones value instead of wrapping.
- R10: The bottleneck vector and the target code stay constant between decisions.
- R11: The instruction-cache and data-cache bits are reported in the vector but do not influence the target choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_issue_width | input | 1 | A ready instruction was held back by issue width |
| ev_dispatch_full | input | 1 | Dispatch stalled on a full issue queue or reorder buffer |
| ev_icache_stall | input | 1 | Fetch stalled on an instruction-cache miss |
| ev_dcache_stall | input | 1 | A load stalled on a data-cache miss |
| ev_mispredict | input | 1 | A branch misprediction resolved |
| ev_l2_stall | input | 1 | An instruction stalled on an L2 miss |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| thr_issue_width | input | THR_W | Issue-width rate threshold, 8 fractional bits |
| thr_dispatch_full | input | THR_W | Dispatch-stall rate threshold |
| thr_icache | input | THR_W | Instruction-cache stall rate threshold |
| thr_dcache | input | THR_W | Data-cache stall rate threshold |
| thr_mispredict | input | THR_W | Misprediction rate threshold |
| thr_l2 | input | THR_W | L2-stall rate threshold |
| bneck_vec | output | 5 | Registered bottleneck vector of the last window |
| target_core | output | 2 | Registered target core code |
| migrate_req | output | 1 | One-cycle request to move to a new core |

## Verification
The main test walks a table of windows. Each row sets a different mix of events above or below a common threshold, one below another, so that each priority rule is picked apart from its neighbours. This includes cases where a frequency bottleneck overrides a width or window bottleneck, and cases where only cache bottlenecks are present. Rows that repeat the previous target tell a real migration apart from a spurious one. Rows at exactly the threshold ratio and one count above it separate the strict comparison from a non-strict one. Directed cases follow. Several instructions retire per cycle to check that the window is counted in instructions, not cycles. Events and retires are driven during the migration hold-off. A window longer than the counter range tells saturation apart from wrap-around.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_EV = 6;
    localparam int EV_WIDTH  = 0;
    localparam int EV_WINDOW = 1;
    localparam int EV_ICACHE = 2;
    localparam int EV_DCACHE = 3;
    localparam int EV_MISP   = 4;
    localparam int EV_L2     = 5;

    localparam int NUM_BN    = 5;
    localparam int BN_WIDTH  = 0;
    localparam int BN_WINDOW = 1;
    localparam int BN_FREQ   = 2;
    localparam int BN_ICACHE = 3;
    localparam int BN_DCACHE = 4;

    typedef enum logic [1:0] {
        CORE_AVG  = 2'd0,
        CORE_WIDE = 2'd1,
        CORE_LWIN = 2'd2,
        CORE_FAST = 2'd3
    } core_t;

    typedef enum logic [1:0] {
        ST_COUNT,
        ST_EVAL,
        ST_DECIDE,
        ST_HOLD
    } steer_st_t;

endpackage

// File: rtl/steer_event_counters.sv
module steer_event_counters
    import steer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           enable,
    input  logic [NUM_EV-1:0]              ev,
    output logic [NUM_EV-1:0][CNT_W-1:0]   ev_cnt,
    output logic [CNT_W-1:0]               cyc_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                ev_cnt[i] <= '0;
            end else if (enable && ev[i] && (ev_cnt[i] != CNT_MAX)) begin
                ev_cnt[i] <= ev_cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cyc_cnt <= '0;
        end else if (enable && (cyc_cnt != CNT_MAX)) begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/steer_retire_window.sv
module steer_retire_window #(
    parameter int WINDOW_INSNS = 10000,
    parameter int RET_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [RET_W-1:0] retire_cnt,
    output logic             window_done
);

    localparam int IW = $clog2(WINDOW_INSNS + (1 << RET_W) + 1);
    localparam logic [IW-1:0] LIMIT = IW'(WINDOW_INSNS);

    logic [IW-1:0] insn_q;
    logic [IW-1:0] insn_sum;

    assign insn_sum    = insn_q + IW'(retire_cnt);
    assign window_done = enable && (insn_sum >= LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            insn_q <= '0;
        end else if (enable) begin
            insn_q <= insn_sum;
        end
    end

endmodule

// File: rtl/steer_bneck_diag.sv
module steer_bneck_diag
    import steer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int THR_W    = 16,
    parameter int THR_FRAC = 8
) (
    input  logic [NUM_EV-1:0][CNT_W-1:0] ev_cnt,
    input  logic [CNT_W-1:0]             cyc_cnt,
    input  logic [NUM_EV-1:0][THR_W-1:0] thr,
    output logic [NUM_BN-1:0]            flags
);

    localparam int PROD_W = CNT_W + THR_W;

    logic [NUM_EV-1:0] over;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_cmp
        logic [PROD_W-1:0] scaled_cnt;
        logic [PROD_W-1:0] scaled_thr;
        assign scaled_cnt = PROD_W'(ev_cnt[i]) << THR_FRAC;
        assign scaled_thr = PROD_W'(thr[i]) * PROD_W'(cyc_cnt);
        assign over[i]    = scaled_cnt > scaled_thr;
    end

    always_comb begin
        flags            = '0;
        flags[BN_WIDTH]  = over[EV_WIDTH];
        flags[BN_WINDOW] = over[EV_WINDOW];
        flags[BN_FREQ]   = over[EV_MISP] | over[EV_L2];
        flags[BN_ICACHE] = over[EV_ICACHE];
        flags[BN_DCACHE] = over[EV_DCACHE];
    end

endmodule

// File: rtl/steer_core_pick.sv
module steer_core_pick
    import steer_pkg::*;
(
    input  logic [NUM_BN-1:0] flags,
    output core_t             pick
);

    logic wid, win, frq;

    assign wid = flags[BN_WIDTH];
    assign win = flags[BN_WINDOW];
    assign frq = flags[BN_FREQ];

    always_comb begin
        if (wid && !frq) begin
            pick = CORE_WIDE;
        end else if (win && !frq) begin
            pick = CORE_LWIN;
        end else if (frq && !wid && !win) begin
            pick = CORE_FAST;
        end else begin
            pick = CORE_AVG;
        end
    end

endmodule

// File: rtl/core_steer_unit.sv
module core_steer_unit
    import steer_pkg::*;
#(
    parameter int WINDOW_INSNS   = 10000,
    parameter int MIGRATE_CYCLES = 100,
    parameter int CNT_W          = 32,
    parameter int THR_W          = 16,
    parameter int THR_FRAC       = 8,
    parameter int RET_W          = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_issue_width,
    input  logic             ev_dispatch_full,
    input  logic             ev_icache_stall,
    input  logic             ev_dcache_stall,
    input  logic             ev_mispredict,
    input  logic             ev_l2_stall,
    input  logic [RET_W-1:0] retire_cnt,
    input  logic [THR_W-1:0] thr_issue_width,
    input  logic [THR_W-1:0] thr_dispatch_full,
    input  logic [THR_W-1:0] thr_icache,
    input  logic [THR_W-1:0] thr_dcache,
    input  logic [THR_W-1:0] thr_mispredict,
    input  logic [THR_W-1:0] thr_l2,
    output logic [4:0]       bneck_vec,
    output logic [1:0]       target_core,
    output logic             migrate_req
);

    localparam int MIG_W = $clog2(MIGRATE_CYCLES + 1);
    localparam logic [MIG_W-1:0] MIG_LOAD = MIG_W'(MIGRATE_CYCLES - 1);

    steer_st_t state_q, state_d;

    logic [NUM_EV-1:0]              ev_vec;
    logic [NUM_EV-1:0][THR_W-1:0]   thr_vec;
    logic [NUM_EV-1:0][CNT_W-1:0]   ev_cnt;
    logic [CNT_W-1:0]               cyc_cnt;
    logic [NUM_BN-1:0]              diag_flags;
    logic [NUM_BN-1:0]              bneck_q;
    core_t                          cur_core_q;
    core_t                          pick;
    logic                           mig_q;
    logic [MIG_W-1:0]               hold_q;
    logic                           count_en;
    logic                           cnt_clear;
    logic                           window_done;
    logic                           core_changes;

    always_comb begin
        ev_vec            = '0;
        ev_vec[EV_WIDTH]  = ev_issue_width;
        ev_vec[EV_WINDOW] = ev_dispatch_full;
        ev_vec[EV_ICACHE] = ev_icache_stall;
        ev_vec[EV_DCACHE] = ev_dcache_stall;
        ev_vec[EV_MISP]   = ev_mispredict;
        ev_vec[EV_L2]     = ev_l2_stall;
    end

    always_comb begin
        thr_vec            = '0;
        thr_vec[EV_WIDTH]  = thr_issue_width;
        thr_vec[EV_WINDOW] = thr_dispatch_full;
        thr_vec[EV_ICACHE] = thr_icache;
        thr_vec[EV_DCACHE] = thr_dcache;
        thr_vec[EV_MISP]   = thr_mispredict;
        thr_vec[EV_L2]     = thr_l2;
    end

    assign count_en     = (state_q == ST_COUNT);
    assign cnt_clear    = (state_q == ST_DECIDE);
    assign core_changes = (pick != cur_core_q);

    steer_event_counters #(
        .CNT_W (CNT_W)
    ) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .enable  (count_en),
        .ev      (ev_vec),
        .ev_cnt  (ev_cnt),
        .cyc_cnt (cyc_cnt)
    );

    steer_retire_window #(
        .WINDOW_INSNS (WINDOW_INSNS),
        .RET_W        (RET_W)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cnt_clear),
        .enable      (count_en),
        .retire_cnt  (retire_cnt),
        .window_done (window_done)
    );

    steer_bneck_diag #(
        .CNT_W    (CNT_W),
        .THR_W    (THR_W),
        .THR_FRAC (THR_FRAC)
    ) u_diag (
        .ev_cnt  (ev_cnt),
        .cyc_cnt (cyc_cnt),
        .thr     (thr_vec),
        .flags   (diag_flags)
    );

    steer_core_pick u_pick (
        .flags (bneck_q),
        .pick  (pick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT:  state_d = window_done ? ST_EVAL : ST_COUNT;
            ST_EVAL:   state_d = ST_DECIDE;
            ST_DECIDE: state_d = core_changes ? ST_HOLD : ST_COUNT;
            ST_HOLD:   state_d = (hold_q == '0) ? ST_COUNT : ST_HOLD;
            default:   state_d = ST_COUNT;
        endcase
    end

    // Output and decision registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bneck_q    <= '0;
            cur_core_q <= CORE_AVG;
            mig_q      <= 1'b0;
            hold_q     <= '0;
        end else begin
            mig_q <= 1'b0;
            unique case (state_q)
                ST_COUNT: begin
                    hold_q <= '0;
                end
                ST_EVAL: begin
                    bneck_q <= diag_flags;
                end
                ST_DECIDE: begin
                    cur_core_q <= pick;
                    mig_q      <= core_changes;
                    hold_q     <= MIG_LOAD;
                end
                ST_HOLD: begin
                    if (hold_q != '0) begin
                        hold_q <= hold_q - 1'b1;
                    end
                end
                default: begin
                    hold_q <= '0;
                end
            endcase
        end
    end

    assign bneck_vec   = bneck_q;
    assign target_core = cur_core_q;
    assign migrate_req = mig_q;

endmodule

// File: rtl/core_steer_checks.sv
module core_steer_checks #(
    parameter int MIGRATE_CYCLES = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] bneck_vec,
    input logic [1:0] target_core,
    input logic       migrate_req
);

    localparam int SW = $clog2(MIGRATE_CYCLES + 2) + 1;
    localparam logic [SW-1:0] SINCE_MAX = SW'(MIGRATE_CYCLES);

    logic [SW-1:0] since_mig;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_mig <= SINCE_MAX;
        end else if (migrate_req) begin
            since_mig <= SW'(1);
        end else if (since_mig < SINCE_MAX) begin
            since_mig <= since_mig + 1'b1;
        end
    end

    AST_MIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        migrate_req |=> !migrate_req); // R7

    AST_MIG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        migrate_req |-> (target_core != $past(target_core))); // R7

    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !migrate_req |-> $stable(target_core)); // R10

    AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        migrate_req |-> (since_mig >= SINCE_MAX)); // R8

    AST_RULE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (migrate_req && target_core == 2'd1) |-> (bneck_vec[0] && !bneck_vec[2])); // R5

    AST_RULE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (migrate_req && target_core == 2'd3) |-> (bneck_vec[2] && !bneck_vec[0] && !bneck_vec[1])); // R5

    AST_NONE_TO_AVG: assert property (@(posedge clk) disable iff (!rst_n)
        (migrate_req && bneck_vec[2:0] == 3'b000) |-> (target_core == 2'd0)); // R6

endmodule

bind core_steer_unit core_steer_checks #(
    .MIGRATE_CYCLES (MIGRATE_CYCLES)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .bneck_vec   (bneck_vec),
    .target_core (target_core),
    .migrate_req (migrate_req)
);

// File: tb/core_steer_unit_test.sv
module core_steer_unit_test;

    localparam int WIN   = 200;
    localparam int MIGC  = 100;
    localparam int CW    = 8;
    localparam int TW    = 16;
    localparam int RW    = 3;
    localparam int NROWS = 13;

    // row: kw, kwin, kic, kdc, kmis, kl2 (8 bits each), expected vector (5), expected core (2)
    localparam logic [54:0] ROWS [0:NROWS-1] = '{
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   5'b00000, 2'd0}, // R6
        {8'd150, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   5'b00001, 2'd1}, // R5 wide
        {8'd150, 8'd150, 8'd0,   8'd0,   8'd0,   8'd0,   5'b00011, 2'd1}, // R5 wide wins, R7 no move
        {8'd0,   8'd150, 8'd0,   8'd0,   8'd0,   8'd0,   5'b00010, 2'd2}, // R5 large window
        {8'd150, 8'd0,   8'd0,   8'd0,   8'd150, 8'd0,   5'b00101, 2'd0}, // R5 frequency blocks wide
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd150, 8'd0,   5'b00100, 2'd3}, // R4 mispredict path
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd150, 5'b00100, 2'd3}, // R4 L2 path
        {8'd0,   8'd150, 8'd0,   8'd0,   8'd0,   8'd150, 5'b00110, 2'd0}, // R5 fallback
        {8'd100, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   5'b00000, 2'd0}, // R3 equality
        {8'd101, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   5'b00001, 2'd1}, // R3 just above
        {8'd0,   8'd0,   8'd200, 8'd150, 8'd0,   8'd0,   5'b11000, 2'd0}, // R11 caches only
        {8'd0,   8'd101, 8'd150, 8'd0,   8'd0,   8'd0,   5'b01010, 2'd2}, // R11 cache ignored
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   5'b00000, 2'd0}  // R6
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ev_issue_width, ev_dispatch_full, ev_icache_stall;
    logic          ev_dcache_stall, ev_mispredict, ev_l2_stall;
    logic [RW-1:0] retire_cnt;
    logic [TW-1:0] thr_issue_width, thr_dispatch_full, thr_icache;
    logic [TW-1:0] thr_dcache, thr_mispredict, thr_l2;
    logic [4:0]    bneck_vec;
    logic [1:0]    target_core;
    logic          migrate_req;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic [4:0] prev_vec  = '0;
    logic [1:0] prev_core = '0;

    always #2 clk = ~clk;

    core_steer_unit #(
        .WINDOW_INSNS   (WIN),
        .MIGRATE_CYCLES (MIGC),
        .CNT_W          (CW),
        .THR_W          (TW),
        .THR_FRAC       (8),
        .RET_W          (RW)
    ) uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .ev_issue_width    (ev_issue_width),
        .ev_dispatch_full  (ev_dispatch_full),
        .ev_icache_stall   (ev_icache_stall),
        .ev_dcache_stall   (ev_dcache_stall),
        .ev_mispredict     (ev_mispredict),
        .ev_l2_stall       (ev_l2_stall),
        .retire_cnt        (retire_cnt),
        .thr_issue_width   (thr_issue_width),
        .thr_dispatch_full (thr_dispatch_full),
        .thr_icache        (thr_icache),
        .thr_dcache        (thr_dcache),
        .thr_mispredict    (thr_mispredict),
        .thr_l2            (thr_l2),
        .bneck_vec         (bneck_vec),
        .target_core       (target_core),
        .migrate_req       (migrate_req)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit w, input bit win, input bit ic, input bit dc,
                         input bit mis, input bit l2, input int ret);
        ev_issue_width   = w;
        ev_dispatch_full = win;
        ev_icache_stall  = ic;
        ev_dcache_stall  = dc;
        ev_mispredict    = mis;
        ev_l2_stall      = l2;
        retire_cnt       = RW'(ret);
    endtask

    task automatic set_thr(input int t);
        thr_issue_width   = TW'(t);
        thr_dispatch_full = TW'(t);
        thr_icache        = TW'(t);
        thr_dcache        = TW'(t);
        thr_mispredict    = TW'(t);
        thr_l2            = TW'(t);
    endtask

    // Starts and ends at a falling edge; event i is high during its first k cycles.
    task automatic run_window(input int kw, input int kwin, input int kic, input int kdc,
                              input int kmis, input int kl2, input int ret, input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            drive(i < kw, i < kwin, i < kic, i < kdc, i < kmis, i < kl2, ret);
            @(posedge clk);
            @(negedge clk);
            if (i == ncyc / 2) begin
                check_eq("R10", "vector held mid-window", int'(bneck_vec), int'(prev_vec));
                check_eq("R10", "target held mid-window", int'(target_core), int'(prev_core));
            end
        end
    endtask

    task automatic hold_off(input bit junk);
        bit saw_req = 1'b0;
        for (int i = 0; i < MIGC; i++) begin
            if (junk) drive(1, 1, 1, 1, 1, 1, 4);
            else      drive(0, 0, 0, 0, 0, 0, 0);
            @(posedge clk);
            @(negedge clk);
            if (i == 0) check_eq("R7", "request lasts one cycle", int'(migrate_req), 0);
            if (migrate_req) saw_req = 1'b1;
        end
        check_eq("R8", "no request during hold-off", int'(saw_req), 0);
    endtask

    task automatic decide(input logic [4:0] ev, input logic [1:0] ec);
        bit mig;
        drive(0, 0, 0, 0, 0, 0, 0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        mig = (ec != prev_core);
        check_eq("R3", "bottleneck vector", int'(bneck_vec), int'(ev));
        check_eq("R5", "target core", int'(target_core), int'(ec));
        check_eq("R7", "migrate request", int'(migrate_req), int'(mig));
        prev_vec  = ev;
        prev_core = ec;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        set_thr(128);
        drive(1, 1, 1, 1, 1, 1, 4);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "vector in reset", int'(bneck_vec), 0);
        check_eq("R1", "target in reset", int'(target_core), 0);
        check_eq("R1", "request in reset", int'(migrate_req), 0);
        rst_n = 1'b1;

        // Table walk, threshold 0.5 on every event, 200-cycle windows
        for (int r = 0; r < NROWS; r++) begin
            logic [54:0] row;
            bit moved;
            row = ROWS[r];
            moved = (row[1:0] != prev_core);
            run_window(int'(row[54:47]), int'(row[46:39]), int'(row[38:31]),
                       int'(row[30:23]), int'(row[22:15]), int'(row[14:7]), 1, WIN);
            decide(row[6:2], row[1:0]);
            if (moved) hold_off(1'b0);
        end

        // R2: four retires per cycle close the window after 50 cycles; 30/50 > 0.5
        run_window(30, 0, 0, 0, 0, 0, 4, WIN / 4);
        decide(5'b00001, 2'd1);
        // R8: activity during hold-off must not leak into the next window
        hold_off(1'b1);
        run_window(0, 0, 0, 0, 0, 0, 1, WIN);
        decide(5'b00000, 2'd0);
        hold_off(1'b0);

        // R3: threshold 0.75 on width; 150/200 equals it, 151/200 exceeds it
        thr_issue_width = TW'(192);
        run_window(150, 0, 0, 0, 0, 0, 1, WIN);
        decide(5'b00000, 2'd0);
        run_window(151, 0, 0, 0, 0, 0, 1, WIN);
        decide(5'b00001, 2'd1);
        hold_off(1'b0);
        thr_issue_width = TW'(128);

        // R9: 500-cycle window with 8-bit counters; width high for 260 cycles
        for (int i = 0; i < 300; i++) begin
            drive(i < 260, 0, 0, 0, 0, 0, 0);
            @(posedge clk);
            @(negedge clk);
        end
        run_window(0, 0, 0, 0, 0, 0, 1, WIN);
        decide(5'b00001, 2'd1);

        // R1: reset in mid-run returns to the average core
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_eq("R1", "target after late reset", int'(target_core), 0);
        check_eq("R1", "vector after late reset", int'(bneck_vec), 0);
        rst_n = 1'b1;

        finish_up();
    end

endmodule